// File: doc/BRIEF.md
# Processor Status Word and Flag Unit

This block keeps the status word of a small integer datapath that works on either bytes or 16-bit words. Each operation presents two operands, an operation kind and a size. A minimal core computes the result. The block then derives carry, parity, half-carry, zero, sign and overflow from the operands and the result. Those flags are registered on the same edge as the strobe that asks for the write.

Three control flags sit beside the arithmetic flags and are loaded through their own write port:

- **Trap enable.** It arms a single-step request.
- **Interrupt enable.** It gates maskable interrupts.
- **Direction.** When set, string index updates count down; when clear, they count up.

When the trap flag is set and an instruction completes, the block raises a single-step request. Acknowledging the request clears both the request and the trap flag.

The operation input is a valid-only stream. There is no ready, so there is no back-pressure. Every cycle with `op_valid` high is taken, and its flags are written on that clock edge. The result output is combinational. Control writes, instruction-complete strobes and acknowledges are plain single-cycle pins.

Top module: `psw_unit`

## Requirements
- R1: After reset (`rst_n` low, active low) `psw` is 0 and `step_req` is 0.
- R2: The flags sit in `psw` at these bit positions:

  | Flag | Bit |
  |------|-----|
  | carry | 0 |
  | parity | 2 |
  | half-carry | 4 |
  | zero | 6 |
  | sign | 7 |
  | trap | 8 |
  | interrupt enable | 9 |
  | direction | 10 |
  | overflow | 11 |

  Bits 1, 3, 5 and 12 to 15 always read 0.
- R3: Add (`op_kind` = 2'b00) has these effects:
  - `result` is (a+b) modulo 2^W, with W = 8 when `op_wide` = 0 and W = 16 when `op_wide` = 1. In byte mode the upper byte of `result` is 0.
  - Carry is the carry out of bit W-1.
  - Half-carry is the carry out of the low four bits.
  - Overflow is set when the signed W-bit sum is out of range.
- R4: Subtract (`op_kind` = 2'b01) has these effects:
  - `result` is (a-b) modulo 2^W.
  - Carry is set when a < b as unsigned W-bit values.
  - Half-carry is set when the low nibble of a is less than the low nibble of b.
  - Overflow is set when the signed W-bit difference is out of range.
- R5: Zero, sign and parity follow the W-bit result for every operation:
  - Zero is set when the W-bit result is 0.
  - Sign equals bit W-1 of the result.
  - Parity is set when bits 7:0 of the result hold an even number of ones, in both sizes.
- R6: Logical operations are AND (`op_kind` = 2'b10) and XOR (`op_kind` = 2'b11). They clear carry and overflow and leave half-carry at its previous value.
- R7: The arithmetic flags change only on an edge where `op_valid` is 1. Operands and kind presented with `op_valid` = 0 leave `psw` unchanged.
- R8: On an edge with `ctl_we` = 1, bits 8, 9 and 10 load `ctl_tf`, `ctl_if` and `ctl_df`, and the arithmetic flags are untouched. Operations never change bits 8 to 10.
- R9: On an edge with `insn_done` = 1, `step_req` becomes 1 if trap was already 1 before that edge. An instruction completing on the edge that sets trap is therefore not trapped. `step_req` then stays 1 until acknowledged.
- R10: On an edge with `step_ack` = 1, trap and `step_req` both become 0. This takes priority over a trap write on the same edge; interrupt enable and direction are still written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present; write arithmetic flags this edge |
| op_kind | input | 2 | 00 add, 01 subtract, 10 AND, 11 XOR |
| op_wide | input | 1 | 1 = 16-bit operation, 0 = byte operation |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| result | output | 16 | Combinational result, upper byte zero in byte mode |
| ctl_we | input | 1 | Load the control flags |
| ctl_tf | input | 1 | Trap flag value to load |
| ctl_if | input | 1 | Interrupt-enable value to load |
| ctl_df | input | 1 | Direction value to load |
| insn_done | input | 1 | Instruction-complete strobe |
| step_ack | input | 1 | Single-step interrupt taken |
| psw | output | 16 | Status word |
| step_req | output | 1 | Single-step interrupt request |

## Verification
The assertions check the following on every cycle:
- The unused bits stay zero.
- Logical operations clear carry and overflow and keep half-carry.
- The status word is stable when nothing writes it.
- A zero result raises the zero flag.
- The handshake rules for arming, holding and acknowledging the single-step request hold.

Only the bench's sweeps can show that the carry, half-carry, overflow and parity values are arithmetically right across sizes. Those sweeps are exhaustive byte adds, dense byte subtracts and logic operations, and pseudo-random word operations. The bench's scenarios also show that the step request skips the instruction that sets the trap flag, and that an acknowledge outranks a simultaneous trap write.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  localparam int BIT_CF = 0;
  localparam int BIT_PF = 2;
  localparam int BIT_AF = 4;
  localparam int BIT_ZF = 6;
  localparam int BIT_SF = 7;
  localparam int BIT_TF = 8;
  localparam int BIT_IF = 9;
  localparam int BIT_DF = 10;
  localparam int BIT_OF = 11;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_XOR = 2'b11
  } op_kind_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } arith_flags_t;
endpackage

// File: rtl/psw_alu.sv
module psw_alu
  import psw_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  op_kind_e          kind,
  input  logic              wide,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] result
);
  localparam logic [WORD_W-1:0] NARROW_MASK = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [WORD_W-1:0] raw;

  always_comb begin
    unique case (kind)
      OP_ADD:  raw = a + b;
      OP_SUB:  raw = a - b;
      OP_AND:  raw = a & b;
      default: raw = a ^ b;
    endcase
    result = wide ? raw : (raw & NARROW_MASK);
  end
endmodule

// File: rtl/psw_flag_gen.sv
module psw_flag_gen
  import psw_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  op_kind_e          kind,
  input  logic              wide,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [WORD_W-1:0] result,
  input  logic              af_prev,
  output arith_flags_t      flags
);
  localparam int NLANE = $clog2(WORD_W / BYTE_W) + 1;
  localparam int SEL_W = (NLANE > 1) ? $clog2(NLANE) : 1;

  logic is_sub;
  logic is_logic;
  logic [NLANE-1:0] lane_cf;
  logic [NLANE-1:0] lane_of;
  logic [NLANE-1:0] lane_zf;
  logic [NLANE-1:0] lane_sf;
  logic [SEL_W-1:0] sel;
  logic nib_carry;
  logic parity_even;

  assign is_sub   = (kind == OP_SUB);
  assign is_logic = (kind == OP_AND) || (kind == OP_XOR);
  assign sel      = wide ? SEL_W'(NLANE - 1) : '0;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LW = BYTE_W << i;
    logic [LW:0] ext;
    logic        sa;
    logic        sb;
    logic        sr;
    always_comb begin
      if (is_sub) ext = {1'b0, a[LW-1:0]} - {1'b0, b[LW-1:0]};
      else        ext = {1'b0, a[LW-1:0]} + {1'b0, b[LW-1:0]};
      sa = a[LW-1];
      sb = b[LW-1];
      sr = result[LW-1];
      lane_cf[i] = ext[LW];
      lane_of[i] = is_sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
      lane_zf[i] = (result[LW-1:0] == '0);
      lane_sf[i] = sr;
    end
  end

  assign nib_carry   = a[NIB_W] ^ b[NIB_W] ^ result[NIB_W];
  assign parity_even = ~^result[BYTE_W-1:0];

  always_comb begin
    flags.pf = parity_even;
    flags.zf = lane_zf[sel];
    flags.sf = lane_sf[sel];
    if (is_logic) begin
      flags.cf = 1'b0;
      flags.of = 1'b0;
      flags.af = af_prev;
    end else begin
      flags.cf = lane_cf[sel];
      flags.of = lane_of[sel];
      flags.af = nib_carry;
    end
  end
endmodule

// File: rtl/psw_step_ctl.sv
module psw_step_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_tf,
  input  logic insn_done,
  input  logic step_ack,
  output logic tf_q,
  output logic step_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tf_q     <= 1'b0;
      step_req <= 1'b0;
    end else begin
      if (step_ack)    tf_q <= 1'b0;
      else if (ctl_we) tf_q <= ctl_tf;

      if (step_ack)                step_req <= 1'b0;
      else if (insn_done && tf_q)  step_req <= 1'b1;
    end
  end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              op_wide,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic [WORD_W-1:0] result,
  input  logic              ctl_we,
  input  logic              ctl_tf,
  input  logic              ctl_if,
  input  logic              ctl_df,
  input  logic              insn_done,
  input  logic              step_ack,
  output logic [15:0]       psw,
  output logic              step_req
);
  op_kind_e     kind;
  arith_flags_t nxt_flags;
  arith_flags_t flags_q;
  logic         tf_q;
  logic         if_q;
  logic         df_q;

  assign kind = op_kind_e'(op_kind);

  psw_alu #(.WORD_W(WORD_W)) u_alu (
    .kind   (kind),
    .wide   (op_wide),
    .a      (opa),
    .b      (opb),
    .result (result)
  );

  psw_flag_gen #(.WORD_W(WORD_W)) u_flags (
    .kind    (kind),
    .wide    (op_wide),
    .a       (opa),
    .b       (opb),
    .result  (result),
    .af_prev (flags_q.af),
    .flags   (nxt_flags)
  );

  psw_step_ctl u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_tf    (ctl_tf),
    .insn_done (insn_done),
    .step_ack  (step_ack),
    .tf_q      (tf_q),
    .step_req  (step_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      if_q    <= 1'b0;
      df_q    <= 1'b0;
    end else begin
      if (op_valid) flags_q <= nxt_flags;
      if (ctl_we) begin
        if_q <= ctl_if;
        df_q <= ctl_df;
      end
    end
  end

  always_comb begin
    psw         = '0;
    psw[BIT_CF] = flags_q.cf;
    psw[BIT_PF] = flags_q.pf;
    psw[BIT_AF] = flags_q.af;
    psw[BIT_ZF] = flags_q.zf;
    psw[BIT_SF] = flags_q.sf;
    psw[BIT_OF] = flags_q.of;
    psw[BIT_TF] = tf_q;
    psw[BIT_IF] = if_q;
    psw[BIT_DF] = df_q;
  end
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [1:0]        op_kind,
  input logic              ctl_we,
  input logic              insn_done,
  input logic              step_ack,
  input logic [WORD_W-1:0] result,
  input logic [15:0]       psw,
  input logic              step_req
);
  // R2: reserved bits read zero
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (psw & 16'hF02A) == 16'h0);

  // R6: logical ops clear carry/overflow and keep half-carry
  a_r6_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind[1]) |=> (!psw[0] && !psw[11]));
  a_r6_af_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind[1]) |=> $stable(psw[4]));

  // R7: no write, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !ctl_we && !step_ack) |=> $stable(psw));

  // R5: zero result raises zero flag
  a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && result == '0) |=> psw[6]);

  // R9: trap armed plus completion raises the request
  a_r9_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && psw[8] && !step_ack) |=> step_req);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !step_ack) |=> step_req);

  // R10: acknowledge clears trap and request
  a_r10_ack: assert property (@(posedge clk) disable iff (!rst_n)
    step_ack |=> (!psw[8] && !step_req));
endmodule

bind psw_unit psw_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .ctl_we    (ctl_we),
  .insn_done (insn_done),
  .step_ack  (step_ack),
  .result    (result),
  .psw       (psw),
  .step_req  (step_req)
);

// File: tb/psw_unit_bench.sv
module psw_unit_bench;
  localparam time CYC = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic        op_wide = 1'b0;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic [15:0] result;
  logic        ctl_we = 1'b0;
  logic        ctl_tf = 1'b0;
  logic        ctl_if = 1'b0;
  logic        ctl_df = 1'b0;
  logic        insn_done = 1'b0;
  logic        step_ack = 1'b0;
  logic [15:0] psw;
  logic        step_req;

  int checks = 0;
  int fails  = 0;

  // bench model of the flag state
  logic m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;
  logic m_tf = 0, m_if = 0, m_df = 0, m_req = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #(CYC/2) clk = ~clk;

  psw_unit u_psw_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_wide(op_wide), .opa(opa), .opb(opb), .result(result),
    .ctl_we(ctl_we), .ctl_tf(ctl_tf), .ctl_if(ctl_if), .ctl_df(ctl_df),
    .insn_done(insn_done), .step_ack(step_ack), .psw(psw), .step_req(step_req)
  );

  function automatic logic [15:0] model_psw();
    logic [15:0] p = '0;
    p[0] = m_cf; p[2] = m_pf; p[4] = m_af; p[6] = m_zf; p[7] = m_sf;
    p[8] = m_tf; p[9] = m_if; p[10] = m_df; p[11] = m_of;
    return p;
  endfunction

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check16(req, psw, model_psw());
    check16(req, {15'd0, step_req}, {15'd0, m_req});
  endtask

  // drive one operation at a negedge; check result now, flags one edge later
  task automatic apply(input logic [1:0] k, input logic w, input logic [15:0] a, input logic [15:0] b);
    int ua, ub, sa, sb, full, lim_hi, lim_lo, sres;
    logic [15:0] er;
    string tag;
    ua = w ? int'(a) : int'(a[7:0]);
    ub = w ? int'(b) : int'(b[7:0]);
    if (w) begin sa = int'($signed(a)); sb = int'($signed(b)); lim_hi = 32767; lim_lo = -32768; end
    else   begin sa = int'($signed(a[7:0])); sb = int'($signed(b[7:0])); lim_hi = 127; lim_lo = -128; end
    case (k)
      2'b00: begin
        full = ua + ub; sres = sa + sb; tag = "R3";
        m_cf = w ? (full > 65535) : (full > 255);
        m_af = ((ua % 16) + (ub % 16)) > 15;
        m_of = (sres > lim_hi) || (sres < lim_lo);
      end
      2'b01: begin
        full = ua - ub; sres = sa - sb; tag = "R4";
        m_cf = ua < ub;
        m_af = (ua % 16) < (ub % 16);
        m_of = (sres > lim_hi) || (sres < lim_lo);
      end
      2'b10: begin full = ua & ub; m_cf = 0; m_of = 0; tag = "R6"; end
      default: begin full = ua ^ ub; m_cf = 0; m_of = 0; tag = "R6"; end
    endcase
    er = w ? 16'(full) : {8'd0, 8'(full)};
    m_zf = (er == 16'd0);
    m_sf = w ? er[15] : er[7];
    m_pf = ($countones(er[7:0]) % 2) == 0;
    op_valid = 1'b1; op_kind = k; op_wide = w; opa = a; opb = b;
    #1;
    check16({tag, " result"}, result, er);
    @(negedge clk);
    op_valid = 1'b0;
    check16({tag, "/R5 flags"}, psw, model_psw());
  endtask

  task automatic ctrl(input logic we, input logic tf, input logic ifl, input logic df,
                      input logic done, input logic ack);
    ctl_we = we; ctl_tf = tf; ctl_if = ifl; ctl_df = df; insn_done = done; step_ack = ack;
    if (ack) m_req = 0;
    else if (done && m_tf) m_req = 1;
    if (ack) m_tf = 0;
    else if (we) m_tf = tf;
    if (we) begin m_if = ifl; m_df = df; end
    @(negedge clk);
    ctl_we = 0; insn_done = 0; step_ack = 0;
  endtask

  initial begin
    #(CYC * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release");

    // R8: control write, arithmetic untouched
    ctrl(1, 0, 1, 1, 0, 0);
    check_state("R8 ctl write");

    // R3: exhaustive byte add
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(2'b00, 1'b0, 16'(a) | 16'hA500, 16'(b) | 16'h5A00);
    // R4: dense byte subtract
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b++)
        apply(2'b01, 1'b0, 16'(a), 16'(b));
    // R6: byte logical, after an add setting AF so that retention shows
    for (int a = 0; a < 256; a += 7)
      for (int b = 0; b < 256; b += 11) begin
        apply(2'b00, 1'b0, 16'h000F, 16'h0001);
        apply(2'(2 + (b & 1)), 1'b0, 16'(a), 16'(b));
      end
    // word ops, pseudo-random plus corners
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(2'(i % 4), 1'b1, lfsr[15:0], lfsr[31:16]);
    end
    apply(2'b00, 1'b1, 16'h7FFF, 16'h0001);
    apply(2'b00, 1'b1, 16'hFFFF, 16'h0001);
    apply(2'b01, 1'b1, 16'h8000, 16'h0001);
    apply(2'b01, 1'b1, 16'h0000, 16'h0001);
    apply(2'b11, 1'b1, 16'h1234, 16'h1234);
    // R5: parity only looks at the low byte in word mode
    apply(2'b10, 1'b1, 16'h0103, 16'hFFFF);

    // R7: operands with op_valid low are ignored
    op_kind = 2'b00; op_wide = 1'b1; opa = 16'hFFFF; opb = 16'h0001;
    @(negedge clk); @(negedge clk);
    check_state("R7 ignored op");

    // R9: instruction that sets TF is not trapped
    ctrl(1, 1, 0, 1, 1, 0);
    check_state("R9 set tf same edge");
    ctrl(0, 0, 0, 0, 1, 0);
    check_state("R9 request raised");
    ctrl(0, 0, 0, 0, 0, 0);
    check_state("R9 request held");
    // R10: ack beats trap write
    ctrl(1, 1, 1, 0, 0, 1);
    check_state("R10 ack priority");
    ctrl(0, 0, 0, 0, 1, 0);
    check_state("R10 no rearm");
    // R8: op does not touch control bits
    ctrl(1, 1, 1, 1, 0, 0);
    apply(2'b01, 1'b0, 16'h0000, 16'h0000);
    check_state("R8 op keeps control");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule